// File: doc/BRIEF.md
# Byte-to-Word Asymmetric Dual-Port RAM

This block is a dual-port memory with two different views of one array, both running on a single clock. The narrow port works one byte at a time and can both read and write. The wide port works one full word at a time and only reads.

The array is held as wide words, each with one write enable per byte. A narrow write becomes a write to a single byte lane of one word, so the storage never needs a read-modify-write cycle. Both ports return read data through two register stages. Each port has its own synchronous clear and its own enable for the output stage.

A typical use is a loader that fills a table one byte at a time while a wide consumer streams words out of it. The depth is set by the wide port's address width.

Top module: `asym_dpram`

## Requirements
- R1: Narrow address `n` refers to byte lane `n[1:0]` of wide word `n >> 2`. Lane 0 is bits 7:0 of the word and lane 3 is bits 31:24.
- R2: A narrow write (`na_en=1`, `na_we=1`) changes only the addressed byte. The other three bytes of that word keep their contents.
- R3: A narrow read (`na_en=1`, `na_we=0`) presented before clock edge k shows the addressed byte on `na_rdata` after edge k+1, when `na_oce` is high at edge k+1.
- R4: A wide read (`wb_en=1`) presented before edge k shows the whole word on `wb_rdata` after edge k+1, when `wb_oce` is high at edge k+1.
- R5: A narrow write cycle does not load the narrow read pipeline. `na_rdata` never shows the written byte, and the first stage keeps the data of the last read.
- R6: With `na_en` low, the narrow port neither writes nor loads a read, whatever `na_we` is.
- R7: While a port's `*_oce` is low, that port's read output holds its value.
- R8: A port's synchronous clear forces its read output, and its first stage, to zero at the next edge, regardless of `*_oce`. Storage is not cleared.
- R9: When the wide port reads a word in the same cycle that the narrow port writes into it, the wide read returns the word as it was before the write.
- R10: The lane select travels down the narrow pipeline with the data. Back-to-back narrow reads of different lanes each return their own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| na_en | input | 1 | Narrow port enable |
| na_we | input | 1 | Narrow write select (only used when enabled) |
| na_clr | input | 1 | Narrow port synchronous clear of the read stages |
| na_oce | input | 1 | Narrow output-stage enable |
| na_addr | input | WORD_AW+2 | Narrow byte address |
| na_wdata | input | 8 | Narrow write byte |
| na_rdata | output | 8 | Narrow read byte |
| wb_en | input | 1 | Wide port read enable |
| wb_clr | input | 1 | Wide port synchronous clear of the read stages |
| wb_oce | input | 1 | Wide output-stage enable |
| wb_addr | input | WORD_AW | Wide word address |
| wb_rdata | output | 32 | Wide read word |

## Verification
Read data is due two edges after the request edge. A clear or a change of output enable takes effect at the next edge. The bench drives inputs at the falling edge. At every rising edge it advances a model of the two stages per port, built over a byte-addressed reference array. It compares both outputs at the following falling edge. A write is applied to the reference only after that edge's reads are modelled, which gives the old-data result for the same-word case.

// File: rtl/asym_dpram.sv
module asym_dpram #(
  parameter int WORD_AW  = 8,
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 32,
  localparam int LANES     = WIDE_W / NARROW_W,
  localparam int SEL_W     = $clog2(LANES),
  localparam int NARROW_AW = WORD_AW + SEL_W,
  localparam int DEPTH     = 1 << WORD_AW
) (
  input  logic                 clk,
  input  logic                 na_en,
  input  logic                 na_we,
  input  logic                 na_clr,
  input  logic                 na_oce,
  input  logic [NARROW_AW-1:0] na_addr,
  input  logic [NARROW_W-1:0]  na_wdata,
  output logic [NARROW_W-1:0]  na_rdata,
  input  logic                 wb_en,
  input  logic                 wb_clr,
  input  logic                 wb_oce,
  input  logic [WORD_AW-1:0]   wb_addr,
  output logic [WIDE_W-1:0]    wb_rdata
);

  logic [LANES-1:0][NARROW_W-1:0] mem [DEPTH];

  logic [WORD_AW-1:0] na_word;
  logic [SEL_W-1:0]   na_lane;
  logic               na_wr;
  logic               na_rd;
  logic [LANES-1:0]   na_be;

  assign na_word = na_addr[NARROW_AW-1:SEL_W];
  assign na_lane = na_addr[SEL_W-1:0];
  assign na_wr   = na_en & na_we;
  assign na_rd   = na_en & ~na_we;
  assign na_be   = {{(LANES-1){1'b0}}, na_wr} << na_lane;

  always_ff @(posedge clk)
    for (int i = 0; i < LANES; i++)
      if (na_be[i]) mem[na_word][i] <= na_wdata;

  logic [LANES-1:0][NARROW_W-1:0] na_q1;
  logic [SEL_W-1:0]               na_sel1;

  always_ff @(posedge clk)
    if (na_clr) begin
      na_q1   <= '0;
      na_sel1 <= '0;
    end else if (na_rd) begin
      na_q1   <= mem[na_word];
      na_sel1 <= na_lane;
    end

  always_ff @(posedge clk)
    if (na_clr)      na_rdata <= '0;
    else if (na_oce) na_rdata <= na_q1[na_sel1];

  logic [WIDE_W-1:0] wb_q1;

  always_ff @(posedge clk)
    if (wb_clr)     wb_q1 <= '0;
    else if (wb_en) wb_q1 <= mem[wb_addr];

  always_ff @(posedge clk)
    if (wb_clr)      wb_rdata <= '0;
    else if (wb_oce) wb_rdata <= wb_q1;

endmodule

module asym_dpram_chk #(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 32
) (
  input logic                clk,
  input logic                na_en,
  input logic                na_we,
  input logic                na_clr,
  input logic                na_oce,
  input logic [NARROW_W-1:0] na_rdata,
  input logic [WIDE_W-1:0]   na_q1,
  input logic                wb_clr,
  input logic                wb_oce,
  input logic [WIDE_W-1:0]   wb_rdata
);

  // R8
  na_clear_chk: assert property (@(posedge clk) na_clr |=> na_rdata == '0 && na_q1 == '0);

  // R8
  wb_clear_chk: assert property (@(posedge clk) wb_clr |=> wb_rdata == '0);

  // R7
  na_hold_chk: assert property (@(posedge clk) disable iff (na_clr) !na_oce |=> $stable(na_rdata));

  // R7
  wb_hold_chk: assert property (@(posedge clk) disable iff (wb_clr) !wb_oce |=> $stable(wb_rdata));

  // R5
  no_change_chk: assert property (@(posedge clk) disable iff (na_clr) (na_en && na_we) |=> $stable(na_q1));

endmodule

bind asym_dpram asym_dpram_chk #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_chk (
  .clk(clk), .na_en(na_en), .na_we(na_we), .na_clr(na_clr), .na_oce(na_oce),
  .na_rdata(na_rdata), .na_q1(na_q1), .wb_clr(wb_clr), .wb_oce(wb_oce), .wb_rdata(wb_rdata)
);

// File: tb/sim_asym_dpram.sv
`timescale 1ns/1ps
module sim_asym_dpram;
  localparam int AW = 4;
  localparam int NB = 1 << (AW + 2);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic na_en = 0, na_we = 0, na_clr = 1, na_oce = 1;
  logic [AW+1:0] na_addr = '0;
  logic [7:0] na_wdata = '0, na_rdata;
  logic wb_en = 0, wb_clr = 1, wb_oce = 1;
  logic [AW-1:0] wb_addr = '0;
  logic [31:0] wb_rdata;

  asym_dpram #(.WORD_AW(AW)) u0 (.*);

  logic [7:0] ref_mem [NB];
  logic [7:0] ma_s1 = 0, ma_out = 0;
  logic [31:0] mb_s1 = 0, mb_out = 0;
  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R8";

  function automatic logic [31:0] word_of(input int w);
    return {ref_mem[4*w+3], ref_mem[4*w+2], ref_mem[4*w+1], ref_mem[4*w]};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string port);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s port %s actual=%h expected=%h", tag, port, act, exp);
    end
  endtask

  task automatic cyc(input logic ae, awe, aclr, aoce, input logic [AW+1:0] aa,
                     input logic [7:0] ad, input logic be, bclr, boce, input logic [AW-1:0] ba);
    na_en = ae; na_we = awe; na_clr = aclr; na_oce = aoce; na_addr = aa; na_wdata = ad;
    wb_en = be; wb_clr = bclr; wb_oce = boce; wb_addr = ba;
    @(posedge clk);
    if (aclr) begin ma_s1 = 0; ma_out = 0; end
    else begin
      if (aoce) ma_out = ma_s1;
      if (ae && !awe) ma_s1 = ref_mem[aa];
    end
    if (bclr) begin mb_s1 = 0; mb_out = 0; end
    else begin
      if (boce) mb_out = mb_s1;
      if (be) mb_s1 = word_of(int'(ba));
    end
    if (ae && awe) ref_mem[aa] = ad;
    @(negedge clk);
    check({24'h0, na_rdata}, {24'h0, ma_out}, "narrow");
    check(wb_rdata, mb_out, "wide");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, '0, '0, 0, 0, 1, '0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NB; i++) ref_mem[i] = 'x;
    @(negedge clk);
    tag = "R8";
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, '0, '0, 0, 1, 1, '0);
    tag = "R2 R5";
    for (int i = 0; i < NB; i++) cyc(1, 1, 0, 1, (AW+2)'(i), 8'(i * 7 + 3), 0, 0, 1, '0);
    tag = "R1 R4";
    for (int w = 0; w < (1 << AW); w++) cyc(0, 0, 0, 1, '0, '0, 1, 0, 1, AW'(w));
    idle(2);
    tag = "R3 R10";
    for (int i = 0; i < NB; i++) cyc(1, 0, 0, 1, (AW+2)'(i), '0, 0, 0, 1, '0);
    idle(2);
    tag = "R2";
    cyc(1, 1, 0, 1, (AW+2)'(5*4+2), 8'hA5, 0, 0, 1, '0);
    cyc(0, 0, 0, 1, '0, '0, 1, 0, 1, AW'(5));
    idle(2);
    tag = "R6";
    cyc(0, 1, 0, 1, '0, 8'hEE, 0, 0, 1, '0);
    cyc(1, 0, 0, 1, '0, '0, 1, 0, 1, '0);
    idle(2);
    tag = "R7";
    cyc(1, 0, 0, 1, 6'd9, '0, 1, 0, 1, AW'(9));
    cyc(1, 0, 0, 0, 6'd10, '0, 1, 0, 0, AW'(10));
    cyc(0, 0, 0, 0, '0, '0, 0, 0, 0, '0);
    idle(2);
    tag = "R9";
    cyc(1, 1, 0, 1, 6'd13, 8'h5C, 1, 0, 1, AW'(3));
    cyc(0, 0, 0, 1, '0, '0, 1, 0, 1, AW'(3));
    idle(2);
    tag = "R8";
    cyc(1, 0, 0, 1, 6'd1, '0, 1, 0, 1, AW'(1));
    cyc(0, 0, 1, 1, '0, '0, 0, 1, 1, '0);
    cyc(0, 0, 1, 0, '0, '0, 0, 1, 0, '0);
    idle(2);
    tag = "R3 R4 R5 R6 R7 R9";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], r[1], (r[7:2] == 0), r[8] | r[9], 6'($urandom), 8'($urandom),
          r[10], (r[16:11] == 0), r[17] | r[18], AW'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule